// File: doc/BRIEF.md
# POST Code Display Driver

This block presents an 8-bit power-on self-test code on a debug header as two hex characters, for an external card that carries two seven-segment digits. In normal operation the byte comes from one of two places: a latch loaded by a write to the legacy diagnostic port address on a simple register write bus, or eight GPIO lines passed straight through. A select input picks between them.

A second mode reports a failed memory module. Firmware presents a CPU index and a DIMM index. The block forms the code from them and flashes it without end. Only reset or an explicit clear input leaves this mode. Each character is also decoded into seven active-high segment signals, so the digits can be checked without the external card.

Top module: `post_code_drv`

## Requirements
- R1: `hdr_o[3:0]` carries the low character (header pins 1 to 4, bit 0 on pin 1) and `hdr_o[7:4]` carries the high character (pins 5 to 8, bit 4 on pin 5).
- R2: A write (`bus_we_i`=1) with `bus_addr_i` equal to `PORT_ADDR` (default 16'h0080) loads `bus_wdata_i` into the port latch at the clock edge. With `src_gpio_i`=0 and the block not in failure mode, the latch is shown from the next cycle. Writes to any other address have no effect.
- R3: With `src_gpio_i`=1 and the block not in failure mode, `hdr_o` equals `gpio_i` in the same cycle.
- R4: A report (`fail_valid_i`=1) with `fail_cpu_i` ≤ 1 and `fail_dimm_i` ≤ 11 enters failure mode at the next edge. The code has high character 4'hA + CPU index (A for CPU 0, B for CPU 1) and the DIMM index as the low character. DIMM 0 is the module furthest from its CPU.
- R5: In failure mode the display flashes with a period of `FLASH_PERIOD` cycles. The code shows for the first `FLASH_PERIOD/2` cycles after capture. For the rest of the period it is blanked, and `hdr_o` then reads 8'hFF.
- R6: Failure mode persists until a clear or a reset. Port writes during failure mode are latched but not shown, and the latched value appears once the mode is cleared.
- R7: `fail_clr_i`=1 leaves failure mode at the next edge. It wins over a report in the same cycle.
- R8: A report with `fail_cpu_i` > 1 or `fail_dimm_i` > 11 is ignored, and the display and mode are unchanged.
- R9: `seg_lo_o` and `seg_hi_o` decode the low and high characters of `hdr_o`, with bit 0 = segment a through bit 6 = segment g. The glyphs are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71.
- R10: After reset the port latch holds 8'h00 and failure mode is off.
- R11: A valid report while already in failure mode replaces the code and restarts the flash phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_addr_i | input | ADDR_W | Register bus address |
| bus_wdata_i | input | 8 | Register bus write data |
| src_gpio_i | input | 1 | 1 = show GPIO lines, 0 = show port latch |
| gpio_i | input | 8 | Raw GPIO code |
| fail_valid_i | input | 1 | DIMM failure report strobe |
| fail_cpu_i | input | 2 | CPU index of the failed module |
| fail_dimm_i | input | 4 | DIMM index of the failed module |
| fail_clr_i | input | 1 | Leave failure mode |
| hdr_o | output | 8 | Header pins 8..1 |
| seg_lo_o | output | 7 | Low digit segments g..a |
| seg_hi_o | output | 7 | High digit segments g..a |
| fail_mode_o | output | 1 | Failure mode active |

## Verification
On every cycle the assertions check the following:
- Failure mode stays set until it is cleared, and a clear takes effect at the next edge.
- Out-of-range reports never enter the mode.
- An accepted report shows its code at once.
- While flashing, the header shows only an A/B character or the blank value.
- GPIO pass-through is exact.

The bench's scenarios cover what the properties cannot: the exact flash phase and duty over whole periods, that a hidden port write appears after the clear, and the full glyph table.

// File: rtl/post_code_pkg.sv
package post_code_pkg;
  localparam int CODE_W = 8;
  localparam int NIB_W  = 4;
  localparam int SEG_W  = 7;
  localparam logic [CODE_W-1:0] BLANK_CODE = 8'hFF;
  localparam logic [NIB_W-1:0]  CPU_BASE   = 4'hA;

  // bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] hex_glyph(input logic [NIB_W-1:0] n);
    case (n)
      4'h0: hex_glyph = 7'h3F;
      4'h1: hex_glyph = 7'h06;
      4'h2: hex_glyph = 7'h5B;
      4'h3: hex_glyph = 7'h4F;
      4'h4: hex_glyph = 7'h66;
      4'h5: hex_glyph = 7'h6D;
      4'h6: hex_glyph = 7'h7D;
      4'h7: hex_glyph = 7'h07;
      4'h8: hex_glyph = 7'h7F;
      4'h9: hex_glyph = 7'h6F;
      4'hA: hex_glyph = 7'h77;
      4'hB: hex_glyph = 7'h7C;
      4'hC: hex_glyph = 7'h39;
      4'hD: hex_glyph = 7'h5E;
      4'hE: hex_glyph = 7'h79;
      default: hex_glyph = 7'h71;
    endcase
  endfunction
endpackage

// File: rtl/post_port_latch.sv
module post_port_latch
  import post_code_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] code_o
);
  logic hit;
  assign hit = we_i && (addr_i == PORT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  code_o <= '0;
    else if (hit) code_o <= wdata_i;
  end
endmodule

// File: rtl/post_fail_ctl.sv
module post_fail_ctl
  import post_code_pkg::*;
#(
  parameter int NUM_CPU      = 2,
  parameter int DIMM_PER_CPU = 12,
  parameter int FLASH_PERIOD = 16,
  parameter int CPU_W        = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CPU_W-1:0]  cpu_i,
  input  logic [NIB_W-1:0]  dimm_i,
  input  logic              clr_i,
  output logic              fail_o,
  output logic              show_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int CNT_W = (FLASH_PERIOD > 2) ? $clog2(FLASH_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FLASH_PERIOD - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(FLASH_PERIOD / 2);

  logic             accept;
  logic [CNT_W-1:0] cnt_q;

  assign accept = valid_i && !clr_i &&
                  (int'(cpu_i) < NUM_CPU) && (int'(dimm_i) < DIMM_PER_CPU);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o <= 1'b0;
      code_o <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      fail_o <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      fail_o <= 1'b1;
      code_o <= {CPU_BASE + NIB_W'(cpu_i), dimm_i};
      cnt_q  <= '0;
    end else if (fail_o) begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign show_o = (cnt_q < HALF);
endmodule

// File: rtl/post_seg_dec.sv
module post_seg_dec
  import post_code_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [SEG_W-1:0] seg_o
);
  assign seg_o = hex_glyph(nib_i);
endmodule

// File: rtl/post_code_drv.sv
module post_code_drv
  import post_code_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80,
  parameter int NUM_CPU      = 2,
  parameter int DIMM_PER_CPU = 12,
  parameter int FLASH_PERIOD = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic              src_gpio_i,
  input  logic [7:0]        gpio_i,
  input  logic              fail_valid_i,
  input  logic [1:0]        fail_cpu_i,
  input  logic [3:0]        fail_dimm_i,
  input  logic              fail_clr_i,
  output logic [7:0]        hdr_o,
  output logic [6:0]        seg_lo_o,
  output logic [6:0]        seg_hi_o,
  output logic              fail_mode_o
);
  localparam int NUM_DIG = CODE_W / NIB_W;

  logic [CODE_W-1:0] port_code, fail_code, norm_code;
  logic              fail_show;
  logic [SEG_W-1:0]  seg_arr [NUM_DIG];

  post_port_latch #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_latch (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .code_o(port_code)
  );

  post_fail_ctl #(
    .NUM_CPU(NUM_CPU), .DIMM_PER_CPU(DIMM_PER_CPU),
    .FLASH_PERIOD(FLASH_PERIOD), .CPU_W(2)
  ) u_fail (
    .clk_i, .rst_ni,
    .valid_i(fail_valid_i), .cpu_i(fail_cpu_i), .dimm_i(fail_dimm_i),
    .clr_i(fail_clr_i),
    .fail_o(fail_mode_o), .show_o(fail_show), .code_o(fail_code)
  );

  assign norm_code = src_gpio_i ? gpio_i : port_code;
  assign hdr_o = fail_mode_o ? (fail_show ? fail_code : BLANK_CODE) : norm_code;

  for (genvar d = 0; d < NUM_DIG; d++) begin : g_dig
    post_seg_dec u_dec (.nib_i(hdr_o[d*NIB_W +: NIB_W]), .seg_o(seg_arr[d]));
  end

  assign seg_lo_o = seg_arr[0];
  assign seg_hi_o = seg_arr[NUM_DIG-1];
endmodule

// File: rtl/post_code_drv_chk.sv
module post_code_drv_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       src_gpio_i,
  input logic [7:0] gpio_i,
  input logic       fail_valid_i,
  input logic [1:0] fail_cpu_i,
  input logic [3:0] fail_dimm_i,
  input logic       fail_clr_i,
  input logic [7:0] hdr_o,
  input logic       fail_mode_o
);
  logic good_rpt;
  assign good_rpt = fail_valid_i && fail_cpu_i <= 2'd1 && fail_dimm_i <= 4'd11;

  AST_CLR_EXITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_clr_i |=> !fail_mode_o); // R7
  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_mode_o && !fail_clr_i) |=> fail_mode_o); // R6
  AST_BAD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fail_mode_o && fail_valid_i && !good_rpt) |=> !fail_mode_o); // R8
  AST_ACCEPT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_rpt && !fail_clr_i) |=>
      (fail_mode_o && hdr_o == {4'hA + {2'b00, $past(fail_cpu_i)}, $past(fail_dimm_i)})); // R4
  AST_FLASH_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_mode_o |-> (hdr_o == 8'hFF || ((hdr_o[7:4] == 4'hA || hdr_o[7:4] == 4'hB)
                                        && hdr_o[3:0] <= 4'd11))); // R5
  AST_GPIO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fail_mode_o && src_gpio_i) |-> hdr_o == gpio_i); // R3
endmodule

bind post_code_drv post_code_drv_chk u_chk (
  .clk_i, .rst_ni, .src_gpio_i, .gpio_i, .fail_valid_i, .fail_cpu_i,
  .fail_dimm_i, .fail_clr_i, .hdr_o, .fail_mode_o
);

// File: tb/post_code_drv_bench.sv
module post_code_drv_bench;
  localparam int P = 8;

  logic clk = 0, rst_ni = 0;
  logic bus_we = 0; logic [15:0] bus_addr = 0; logic [7:0] bus_wdata = 0;
  logic src_gpio = 0; logic [7:0] gpio = 0;
  logic fvalid = 0; logic [1:0] fcpu = 0; logic [3:0] fdimm = 0; logic fclr = 0;
  logic [7:0] hdr; logic [6:0] seg_lo, seg_hi; logic fmode;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R10";

  post_code_drv #(.FLASH_PERIOD(P)) u_post_code_drv (
    .clk_i(clk), .rst_ni, .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .src_gpio_i(src_gpio), .gpio_i(gpio),
    .fail_valid_i(fvalid), .fail_cpu_i(fcpu), .fail_dimm_i(fdimm),
    .fail_clr_i(fclr), .hdr_o(hdr), .seg_lo_o(seg_lo), .seg_hi_o(seg_hi),
    .fail_mode_o(fmode)
  );

  always #5 clk = ~clk;

  function automatic logic [6:0] glyph(input int n);
    int tbl[16] = '{'h3F,'h06,'h5B,'h4F,'h66,'h6D,'h7D,'h07,
                    'h7F,'h6F,'h77,'h7C,'h39,'h5E,'h79,'h71};
    return 7'(tbl[n]);
  endfunction

  // behavioural reference
  int m_p80 = 0, m_code = 0, m_ph = 0; bit m_fail = 0;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin m_p80 = 0; m_fail = 0; m_ph = 0; end
    else begin
      if (bus_we && bus_addr == 16'h0080) m_p80 = bus_wdata;
      if (fclr) begin m_fail = 0; m_ph = 0; end
      else if (fvalid && fcpu < 2 && fdimm < 12) begin
        m_fail = 1; m_code = (10 + fcpu) * 16 + fdimm; m_ph = 0;
      end else if (m_fail) m_ph = (m_ph + 1) % P;
    end
  end

  function automatic int exp_hdr();
    if (m_fail) return (m_ph < P/2) ? m_code : 255;
    return src_gpio ? int'(gpio) : m_p80;
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    cyc++;
    chk({tag, " hdr"}, hdr, exp_hdr());
    chk("R9 seg_lo", seg_lo, glyph(exp_hdr() % 16));
    chk("R9 seg_hi", seg_hi, glyph(exp_hdr() / 16));
    chk({tag, " mode"}, fmode, m_fail);
  end

  initial begin : wdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic nxt(); @(negedge clk); #2; endtask
  task automatic idle(); bus_we = 0; fvalid = 0; fclr = 0; endtask

  initial begin
    #23 rst_ni = 1; nxt();
    chk("R10 reset hdr", hdr, 8'h00);
    chk("R10 reset mode", fmode, 0);

    tag = "R2"; bus_we = 1; bus_addr = 16'h0080; bus_wdata = 8'h3C; nxt(); idle();
    chk("R2 port write", hdr, 8'h3C);
    chk("R1 low char", hdr[3:0], 4'hC);
    chk("R1 high char", hdr[7:4], 4'h3);
    bus_we = 1; bus_addr = 16'h0081; bus_wdata = 8'h55; nxt(); idle();
    chk("R2 other addr ignored", hdr, 8'h3C);

    tag = "R3"; src_gpio = 1; gpio = 8'hA7; #1;
    chk("R3 gpio same cycle", hdr, 8'hA7);
    nxt(); gpio = 8'h5E; #1; chk("R3 gpio change", hdr, 8'h5E);
    for (int v = 0; v < 16; v++) begin
      gpio = 8'(v * 17); nxt(); #1;
      chk("R9 glyph", seg_lo, glyph(v));
    end
    src_gpio = 0; nxt();
    chk("R2 back to latch", hdr, 8'h3C);

    tag = "R8"; fvalid = 1; fcpu = 2; fdimm = 3; nxt(); idle();
    chk("R8 bad cpu idle", fmode, 0);

    tag = "R4"; fvalid = 1; fcpu = 0; fdimm = 0; nxt(); idle();
    chk("R4 cpu0 dimm0", hdr, 8'hA0);
    tag = "R5";
    repeat (P/2 - 1) nxt();
    chk("R5 last shown", hdr, 8'hA0);
    nxt(); chk("R5 blank", hdr, 8'hFF);
    repeat (P/2) nxt();
    chk("R5 period wrap", hdr, 8'hA0);

    tag = "R6"; bus_we = 1; bus_addr = 16'h0080; bus_wdata = 8'h99; nxt(); idle();
    repeat (3 * P) nxt();
    chk("R6 sticky", fmode, 1);

    tag = "R8"; fvalid = 1; fcpu = 1; fdimm = 12; nxt(); idle();
    chk("R8 bad dimm keeps mode", fmode, 1);
    fvalid = 1; fcpu = 3; fdimm = 1; nxt(); idle();

    tag = "R11"; repeat (P/2) nxt();
    fvalid = 1; fcpu = 1; fdimm = 11; nxt(); idle();
    chk("R11 replace code", hdr, 8'hBB);
    chk("R4 seg b", seg_hi, 7'h7C);
    repeat (P) nxt();

    tag = "R7"; fclr = 1; fvalid = 1; fcpu = 0; fdimm = 5; nxt(); idle();
    chk("R7 clear wins", fmode, 0);
    chk("R6 hidden write shown", hdr, 8'h99);
    repeat (3) nxt();

    rst_ni = 0; #1; tag = "R10"; rst_ni = 1; nxt();
    chk("R10 reset clears latch", hdr, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule